// File: doc/BRIEF.md
# Drawing Command Packet Framer

This block sits on the drawing-data port of a graphics engine. It takes a stream of 32-bit words and groups them into complete command packets. The top byte of the first word of each packet (the opcode) sets the packet's length, either from a fixed size computed from the opcode or, for polylines, from a terminating word found in the stream. Each complete packet is held in a small buffer and offered downstream with its header and length. Downstream logic reads the buffered words through an index port and releases the packet with a ready strobe.

Three opcode classes are not emitted as packets. Environment-setting words are written into a bank of eight registers, and two status fields are refreshed from that bank. Image-transfer commands are gathered as three words and turned into a start request for a separate memory transfer engine. For a transfer into memory, the port then stops parsing and forwards raw words to that engine until the engine reports the transfer finished. A command-path reset input drops any packet that is only partly received.

Top module: `cmd_packet_framer`

## Requirements
- R1: The packet length equals 1 plus an extra-word count derived from opcode = word[31:24]. Expected lengths: 0x00 gives 1, 0x02 gives 3, 0x20 gives 4, 0x2C gives 9, 0x3C gives 12, 0x60 gives 3, 0x68 gives 2, 0x6C gives 1 and 0x80 gives 4. The packet is offered with `pkt_valid` on the cycle after its last word is accepted, and `pkt_header` holds the first word.
- R2: For opcodes 0x48–0x4F, the packet ends on the first word at index 3 or higher (the header is index 0) for which (word & 0xF000F000) == 0x50005000. That terminating word is counted in `pkt_len`. Matching words at indices 1 and 2 do not end the packet.
- R3: For opcodes 0x58–0x5F, the terminating pattern of R2 is tested only at even indices of 4 or higher. Matching words at odd indices do not end the packet.
- R4: Opcodes 0xA0–0xDF consume exactly three words: opcode, position and size. `xfer_start` pulses for one cycle after the third word, and no earlier. `xfer_pos` and `xfer_size` carry words 1 and 2. `xfer_is_read` is 1 exactly when (opcode & 0xE0) == 0xC0. No packet is offered for these opcodes.
- R5: An opcode with (opcode & 0xF8) == 0xE0 stores the whole word into environment register opcode[2:0] (bits 32*k+31:32*k of `env_regs`) and offers no packet.
- R6: One cycle after an environment register changes, `status_low[10:0]` equals register 1 bits [10:0] and `status_low[12:11]` equals register 6 bits [1:0].
- R7: After a write transfer has started, `word_ready` stays 0 until `xfer_wr_active` rises. While `xfer_wr_active` is high, words are passed to `raw_valid`/`raw_data` and are not parsed. Parsing resumes with a new opcode once `xfer_wr_active` falls.
- R8: While `pkt_valid` is high, `word_ready` is 0 and the header and length stay stable until `pkt_ready`. `rd_word` returns stored word `rd_idx`, with index 0 being the header.
- R9: `cmd_reset` discards any partly received or pending packet. The next accepted word is then parsed as an opcode. Environment registers are kept.
- R10: `pkt_len` saturates at 2^LEN_W-1 for polylines longer than that.
- R11: After `rst_n` is low, environment register k holds (0xE0+k)<<24, `status_low` is 0, `pkt_valid` and `xfer_start` are 0, and `word_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_reset | input | 1 | Command-path reset: drop partial packet |
| word_valid | input | 1 | Input word valid |
| word_data | input | 32 | Input word |
| word_ready | output | 1 | Input word accepted when high with valid |
| xfer_wr_active | input | 1 | Transfer engine is consuming write data |
| raw_valid | output | 1 | Raw word forwarded to the transfer engine |
| raw_data | output | 32 | Raw word |
| pkt_valid | output | 1 | Complete packet offered |
| pkt_ready | input | 1 | Downstream releases the packet |
| pkt_header | output | 32 | First word of the packet |
| pkt_len | output | LEN_W | Word count of the packet |
| rd_idx | input | $clog2(BUF_DEPTH) | Buffered word index |
| rd_word | output | 32 | Buffered word at rd_idx |
| xfer_start | output | 1 | One-cycle transfer start request |
| xfer_is_read | output | 1 | Transfer direction is read |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| env_regs | output | 256 | Eight environment registers, register k at bits 32*k+31:32*k |
| status_low | output | 13 | Status bits derived from registers 1 and 6 |

## Verification
The bench builds the framer with BUF_DEPTH=4 and LEN_W=6. A length field of six bits lets a 71-word polyline drive the length counter into saturation within a short run. A four-word buffer gives an index port of only two bits, which is still enough to read the header and early words back. The position capture for image commands needs indices 1 and 2, so this depth still exercises the full transfer path.

// File: rtl/framer_pkg.sv
// framer_pkg: shared types for the drawing command packet framer.
// Assumes 32-bit words with the opcode in bits [31:24].
package framer_pkg;

    // Framer control states
    typedef enum logic [1:0] {
        S_COLLECT = 2'd0,
        S_PKT     = 2'd1,
        S_XWAIT   = 2'd2,
        S_XRAW    = 2'd3
    } fr_state_e;

    // Decoded properties of an opcode
    typedef struct packed {
        logic [3:0] extra;     // fixed words after the header (minimum for polylines)
        logic       is_poly;   // terminated by a sentinel word
        logic       poly_gour; // sentinel checked on even indices only
        logic       is_image;  // memory transfer command
        logic       img_read;  // transfer direction is read
        logic       is_env;    // environment register write
    } cmd_info_t;

    localparam logic [31:0] SENT_MASK  = 32'hF000_F000;
    localparam logic [31:0] SENT_VALUE = 32'h5000_5000;

endpackage

// File: rtl/opcode_decoder.sv
// opcode_decoder: maps an opcode byte to its packet class and fixed length.
// Purely combinational; lengths are computed from opcode bit fields.
module opcode_decoder
    import framer_pkg::*;
(
    input  logic [7:0] opcode,
    output cmd_info_t  info
);
    logic [3:0] verts;
    logic [3:0] per_vert;

    // Derive vertex count and words per vertex for polygon opcodes
    always_comb begin
        verts    = opcode[3] ? 4'd4 : 4'd3;
        per_vert = opcode[2] ? 4'd2 : 4'd1;
    end

    // Classify the opcode and compute its extra-word count
    always_comb begin
        info = '0;
        if (opcode == 8'h02) begin
            info.extra = 4'd2;
        end else if (opcode[7:5] == 3'b001) begin
            info.extra = (verts * per_vert) + (opcode[4] ? verts - 4'd1 : 4'd0);
        end else if (opcode[7:5] == 3'b010) begin
            info.extra     = 4'd2 + {3'd0, opcode[4]} + {3'd0, opcode[3]};
            info.is_poly   = opcode[3];
            info.poly_gour = opcode[4];
        end else if (opcode[7:5] == 3'b011) begin
            if (opcode[4:2] == 3'b011)
                info.extra = 4'd0;
            else
                info.extra = ((opcode[4:3] == 2'b00) ? 4'd2 : 4'd1) + {3'd0, opcode[2]};
        end else if (opcode == 8'h80) begin
            info.extra = 4'd3;
        end else if (opcode >= 8'hA0 && opcode <= 8'hDF) begin
            info.extra    = 4'd2;
            info.is_image = 1'b1;
            info.img_read = (opcode[7:5] == 3'b110);
        end else if (opcode[7:3] == 5'b11100) begin
            info.is_env = 1'b1;
        end
    end
endmodule

// File: rtl/env_reg_bank.sv
// env_reg_bank: eight 32-bit environment registers plus derived status bits.
// Status is registered, so it follows a register write by one cycle.
module env_reg_bank #(
    parameter int NREG = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [2:0]         wsel,
    input  logic [31:0]        wdata,
    output logic [NREG*32-1:0] regs_flat,
    output logic [12:0]        status_q
);
    logic [31:0] regs [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        localparam logic [7:0] RST_TOP = 8'hE0 + 8'(k);
        // Hold one environment register, loaded when selected
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[k] <= {RST_TOP, 24'd0};
            else if (we && (int'(wsel) == k))
                regs[k] <= wdata;
        end
        assign regs_flat[k*32 +: 32] = regs[k];
    end

    // Refresh status fields from registers 1 and 6
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= {regs[6][1:0], regs[1][10:0]};
    end
endmodule

// File: rtl/packet_buffer.sv
// packet_buffer: word storage for the packet being received.
// Writes land at an index; reads are combinational. No reset on data.
module packet_buffer #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [31:0]      rdata
);
    logic [31:0] mem [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_word
        // Store a word when its slot is addressed
        always_ff @(posedge clk) begin
            if (we && (int'(waddr) == k))
                mem[k] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cmd_packet_framer.sv
// cmd_packet_framer: groups a word stream into drawing command packets,
// captures environment words, starts image transfers and forwards raw
// write data. Assumes the transfer engine always accepts raw words and
// raises xfer_wr_active some cycles after a write start. LEN_W >= 5,
// BUF_DEPTH >= 4 and a power of two.
module cmd_packet_framer
    import framer_pkg::*;
#(
    parameter int BUF_DEPTH = 16,
    parameter int LEN_W     = 12,
    localparam int IDX_W    = $clog2(BUF_DEPTH),
    localparam int NENV     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_reset,
    input  logic               word_valid,
    input  logic [31:0]        word_data,
    output logic               word_ready,
    input  logic               xfer_wr_active,
    output logic               raw_valid,
    output logic [31:0]        raw_data,
    output logic               pkt_valid,
    input  logic               pkt_ready,
    output logic [31:0]        pkt_header,
    output logic [LEN_W-1:0]   pkt_len,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [31:0]        rd_word,
    output logic               xfer_start,
    output logic               xfer_is_read,
    output logic [31:0]        xfer_pos,
    output logic [31:0]        xfer_size,
    output logic [NENV*32-1:0] env_regs,
    output logic [12:0]        status_low
);
    localparam logic [LEN_W-1:0] IDX_MAX = '1;

    fr_state_e        state_q;
    logic [LEN_W-1:0] idx_q;
    logic [31:0]      hdr_q;
    cmd_info_t        info_q;
    cmd_info_t        dec_info;
    logic [31:0]      pkt_hdr_q;
    logic [LEN_W-1:0] pkt_len_q;
    logic             xs_q, xrd_q;
    logic [31:0]      xpos_q, xsize_q;

    logic             collecting, take, at_head;
    logic             sentinel, chk_pos, last_word;
    logic [LEN_W-1:0] idx_inc;
    logic             env_we, buf_we;

    opcode_decoder u_dec (
        .opcode (word_data[31:24]),
        .info   (dec_info)
    );

    // Accept, sentinel and end-of-packet conditions
    always_comb begin
        collecting = (state_q == S_COLLECT);
        take       = collecting && word_valid && !cmd_reset;
        at_head    = (idx_q == '0);
        sentinel   = ((word_data & SENT_MASK) == SENT_VALUE);
        chk_pos    = info_q.poly_gour ? ((idx_q >= LEN_W'(4)) && !idx_q[0])
                                      : (idx_q >= LEN_W'(3));
        last_word  = info_q.is_poly ? (chk_pos && sentinel)
                                    : (idx_q == LEN_W'(info_q.extra));
        idx_inc    = (idx_q == IDX_MAX) ? idx_q : idx_q + LEN_W'(1);
        env_we     = take && at_head && dec_info.is_env;
        buf_we     = take && (int'(idx_q) < BUF_DEPTH);
    end

    // Handshake and raw forwarding toward the transfer engine
    always_comb begin
        word_ready = collecting || ((state_q == S_XRAW) && xfer_wr_active);
        raw_valid  = (state_q == S_XRAW) && xfer_wr_active && word_valid;
        raw_data   = word_data;
    end

    packet_buffer #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (idx_q[IDX_W-1:0]),
        .wdata (word_data),
        .raddr (rd_idx),
        .rdata (rd_word)
    );

    env_reg_bank #(.NREG(NENV)) u_env (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (env_we),
        .wsel      (word_data[26:24]),
        .wdata     (word_data),
        .regs_flat (env_regs),
        .status_q  (status_low)
    );

    // Framing state machine: header decode, word counting, packet offer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_COLLECT;
            idx_q     <= '0;
            hdr_q     <= '0;
            info_q    <= '0;
            pkt_hdr_q <= '0;
            pkt_len_q <= '0;
            xs_q      <= 1'b0;
            xrd_q     <= 1'b0;
            xpos_q    <= '0;
            xsize_q   <= '0;
        end else begin
            xs_q <= 1'b0;
            if (cmd_reset) begin
                state_q <= S_COLLECT;
                idx_q   <= '0;
            end else begin
                case (state_q)
                    S_COLLECT: begin
                        if (word_valid) begin
                            if (at_head) begin
                                hdr_q  <= word_data;
                                info_q <= dec_info;
                                if (dec_info.is_env) begin
                                    idx_q <= '0;
                                end else if (!dec_info.is_poly && dec_info.extra == 4'd0) begin
                                    pkt_hdr_q <= word_data;
                                    pkt_len_q <= LEN_W'(1);
                                    state_q   <= S_PKT;
                                end else begin
                                    idx_q <= LEN_W'(1);
                                end
                            end else begin
                                if (info_q.is_image && idx_q == LEN_W'(1))
                                    xpos_q <= word_data;
                                if (last_word) begin
                                    idx_q <= '0;
                                    if (info_q.is_image) begin
                                        xs_q    <= 1'b1;
                                        xrd_q   <= info_q.img_read;
                                        xsize_q <= word_data;
                                        state_q <= info_q.img_read ? S_COLLECT : S_XWAIT;
                                    end else begin
                                        pkt_hdr_q <= hdr_q;
                                        pkt_len_q <= idx_inc;
                                        state_q   <= S_PKT;
                                    end
                                end else begin
                                    idx_q <= idx_inc;
                                end
                            end
                        end
                    end
                    S_PKT:   if (pkt_ready) state_q <= S_COLLECT;
                    S_XWAIT: if (xfer_wr_active) state_q <= S_XRAW;
                    S_XRAW:  if (!xfer_wr_active) state_q <= S_COLLECT;
                    default: state_q <= S_COLLECT;
                endcase
            end
        end
    end

    assign pkt_valid    = (state_q == S_PKT);
    assign pkt_header   = pkt_hdr_q;
    assign pkt_len      = pkt_len_q;
    assign xfer_start   = xs_q;
    assign xfer_is_read = xrd_q;
    assign xfer_pos     = xpos_q;
    assign xfer_size    = xsize_q;
endmodule

// File: rtl/framer_checker.sv
// framer_checker: temporal properties of cmd_packet_framer, bound below.
module framer_checker #(
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_reset,
    input logic             word_valid,
    input logic             word_ready,
    input logic             xfer_wr_active,
    input logic             raw_valid,
    input logic             pkt_valid,
    input logic             pkt_ready,
    input logic [31:0]      pkt_header,
    input logic [LEN_W-1:0] pkt_len,
    input logic             xfer_start,
    input logic [255:0]     env_regs,
    input logic [12:0]      status_low
);
    a_r1_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len != '0));

    a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    a_r4_start_not_pkt: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !pkt_valid);

    a_r6_status_track: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (status_low == {$past(env_regs[193:192]), $past(env_regs[42:32])}));

    a_r7_raw_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid |-> (xfer_wr_active && word_valid && word_ready));

    a_r7_raw_excl_pkt: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid |-> !pkt_valid);

    a_r8_pkt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready && !cmd_reset) |=>
            (pkt_valid && $stable(pkt_header) && $stable(pkt_len)));

    a_r8_no_take_while_pkt: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !word_ready);

    a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (!pkt_valid && !xfer_start));
endmodule

bind cmd_packet_framer framer_checker #(.LEN_W(LEN_W)) u_framer_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_reset      (cmd_reset),
    .word_valid     (word_valid),
    .word_ready     (word_ready),
    .xfer_wr_active (xfer_wr_active),
    .raw_valid      (raw_valid),
    .pkt_valid      (pkt_valid),
    .pkt_ready      (pkt_ready),
    .pkt_header     (pkt_header),
    .pkt_len        (pkt_len),
    .xfer_start     (xfer_start),
    .env_regs       (env_regs),
    .status_low     (status_low)
);

// File: tb/tb_cmd_packet_framer.sv
// Directed bench for cmd_packet_framer: one task per scenario.
module tb_cmd_packet_framer;
    localparam int BUF_DEPTH = 4;
    localparam int LEN_W     = 6;
    localparam int IDX_W     = $clog2(BUF_DEPTH);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_reset = 1'b0;
    logic               word_valid = 1'b0;
    logic [31:0]        word_data = '0;
    logic               word_ready;
    logic               xfer_wr_active = 1'b0;
    logic               raw_valid;
    logic [31:0]        raw_data;
    logic               pkt_valid;
    logic               pkt_ready = 1'b0;
    logic [31:0]        pkt_header;
    logic [LEN_W-1:0]   pkt_len;
    logic [IDX_W-1:0]   rd_idx = '0;
    logic [31:0]        rd_word;
    logic               xfer_start;
    logic               xfer_is_read;
    logic [31:0]        xfer_pos;
    logic [31:0]        xfer_size;
    logic [255:0]       env_regs;
    logic [12:0]        status_low;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    cmd_packet_framer #(.BUF_DEPTH(BUF_DEPTH), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset),
        .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
        .xfer_wr_active(xfer_wr_active), .raw_valid(raw_valid), .raw_data(raw_data),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_header(pkt_header),
        .pkt_len(pkt_len), .rd_idx(rd_idx), .rd_word(rd_word),
        .xfer_start(xfer_start), .xfer_is_read(xfer_is_read),
        .xfer_pos(xfer_pos), .xfer_size(xfer_size),
        .env_regs(env_regs), .status_low(status_low)
    );

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // Drive one parsed word; returns at the negedge after acceptance
    task automatic send_word(input logic [31:0] w);
        logic acc;
        word_valid = 1'b1;
        word_data  = w;
        do begin
            #1 acc = word_ready;
            @(posedge clk);
            @(negedge clk);
        end while (!acc);
        word_valid = 1'b0;
    endtask

    task automatic ack_pkt();
        pkt_ready = 1'b1;
        @(negedge clk);
        pkt_ready = 1'b0;
    endtask

    task automatic t_reset();
        for (int k = 0; k < 8; k++)
            check("R11 env reset", env_regs[k*32 +: 32], {8'hE0 + 8'(k), 24'd0});
        check("R11 status reset", 32'(status_low), 32'd0);
        check("R11 pkt_valid reset", 32'(pkt_valid), 32'd0);
        check("R11 xfer_start reset", 32'(xfer_start), 32'd0);
        check("R11 word_ready reset", 32'(word_ready), 32'd1);
    endtask

    // R1: fixed-length packet of the expected size
    task automatic t_fixed(input logic [7:0] op, input int exp_len);
        logic [31:0] hdr;
        hdr = {op, 24'h00_1234};
        send_word(hdr);
        for (int k = 1; k < exp_len; k++) begin
            check("R1 not early", 32'(pkt_valid), 32'd0);
            send_word(32'h0000_0100 + 32'(k));
        end
        check("R1 pkt_valid", 32'(pkt_valid), 32'd1);
        check("R1 pkt_header", pkt_header, hdr);
        check("R1 pkt_len", 32'(pkt_len), 32'(exp_len));
        ack_pkt();
    endtask

    // R8: hold while not released and read back buffered words
    task automatic t_hold_read();
        send_word(32'h2000_00AA);
        send_word(32'h1111_1111);
        send_word(32'h2222_2222);
        send_word(32'h3333_3333);
        @(negedge clk);
        check("R8 held valid", 32'(pkt_valid), 32'd1);
        check("R8 ready low", 32'(word_ready), 32'd0);
        check("R8 len stable", 32'(pkt_len), 32'd4);
        rd_idx = 2'd0; #1;
        check("R8 rd header", rd_word, 32'h2000_00AA);
        rd_idx = 2'd2; #1;
        check("R8 rd word2", rd_word, 32'h2222_2222);
        ack_pkt();
        check("R8 released", 32'(pkt_valid), 32'd0);
    endtask

    // R2: flat polyline, sentinels before index 3 ignored
    task automatic t_poly_flat();
        send_word(32'h4800_0000);
        send_word(32'h5000_5000);
        send_word(32'h5123_5456);
        check("R2 no end at idx2", 32'(pkt_valid), 32'd0);
        send_word(32'h0000_0000);
        check("R2 no end at idx3 plain", 32'(pkt_valid), 32'd0);
        send_word(32'h5555_5555);
        check("R2 pkt_valid", 32'(pkt_valid), 32'd1);
        check("R2 pkt_len", 32'(pkt_len), 32'd5);
        ack_pkt();
    endtask

    // R3: shaded polyline, sentinel only at even index >= 4
    task automatic t_poly_gour();
        send_word(32'h5800_0000);
        send_word(32'h0001_0001);
        send_word(32'h0002_0002);
        send_word(32'h5000_5000);
        check("R3 odd idx3 ignored", 32'(pkt_valid), 32'd0);
        send_word(32'h0102_0304);
        send_word(32'h5000_5000);
        check("R3 odd idx5 ignored", 32'(pkt_valid), 32'd0);
        send_word(32'h5FFF_5FFF);
        check("R3 pkt_valid", 32'(pkt_valid), 32'd1);
        check("R3 pkt_len", 32'(pkt_len), 32'd7);
        ack_pkt();
    endtask

    // R10: length saturates for a long polyline
    task automatic t_saturate();
        send_word(32'h4A00_0000);
        for (int k = 1; k < 70; k++) send_word(32'h0000_0000);
        send_word(32'h5000_5000);
        check("R10 pkt_valid", 32'(pkt_valid), 32'd1);
        check("R10 saturated len", 32'(pkt_len), 32'd63);
        ack_pkt();
    endtask

    // R4/R7: write transfer start, raw forwarding, parsing resumes
    task automatic t_image_write();
        send_word(32'hA000_0000);
        send_word(32'h0010_0020);
        check("R4 no start before third", 32'(xfer_start), 32'd0);
        send_word(32'h0002_0004);
        check("R4 start pulse", 32'(xfer_start), 32'd1);
        check("R4 is_read write", 32'(xfer_is_read), 32'd0);
        check("R4 pos", xfer_pos, 32'h0010_0020);
        check("R4 size", xfer_size, 32'h0002_0004);
        check("R4 no packet", 32'(pkt_valid), 32'd0);
        check("R7 wait ready low", 32'(word_ready), 32'd0);
        xfer_wr_active = 1'b1;
        @(negedge clk);
        check("R4 single pulse", 32'(xfer_start), 32'd0);
        word_valid = 1'b1;
        word_data  = 32'h6800_0000;
        #1;
        check("R7 raw_valid", 32'(raw_valid), 32'd1);
        check("R7 raw_data", raw_data, 32'h6800_0000);
        @(negedge clk);
        word_data = 32'hA000_0000;
        @(negedge clk);
        word_valid = 1'b0;
        check("R7 raw not parsed", 32'(pkt_valid), 32'd0);
        xfer_wr_active = 1'b0;
        @(negedge clk);
        send_word(32'h0000_0007);
        check("R7 resume pkt", 32'(pkt_valid), 32'd1);
        check("R7 resume header", pkt_header, 32'h0000_0007);
        check("R7 resume len", 32'(pkt_len), 32'd1);
        ack_pkt();
    endtask

    // R4: read transfer direction and immediate return to parsing
    task automatic t_image_read();
        send_word(32'hC000_0000);
        send_word(32'h0003_0004);
        send_word(32'h0001_0001);
        check("R4 read start", 32'(xfer_start), 32'd1);
        check("R4 is_read", 32'(xfer_is_read), 32'd1);
        check("R4 read ready", 32'(word_ready), 32'd1);
    endtask

    // R5/R6: environment writes and derived status
    task automatic t_env();
        send_word(32'hE100_0ABC);
        check("R5 env1", env_regs[1*32 +: 32], 32'hE100_0ABC);
        check("R5 no packet", 32'(pkt_valid), 32'd0);
        check("R6 status lags", 32'(status_low), 32'd0);
        @(negedge clk);
        check("R6 status env1", 32'(status_low), 32'h02BC);
        send_word(32'hE600_0003);
        @(negedge clk);
        check("R6 status env6", 32'(status_low), 32'h1ABC);
        send_word(32'hE500_1234);
        @(negedge clk);
        check("R5 env5", env_regs[5*32 +: 32], 32'hE500_1234);
        check("R6 status unchanged", 32'(status_low), 32'h1ABC);
    endtask

    // R9: command-path reset drops a partial packet
    task automatic t_cmd_reset();
        send_word(32'h2000_0000);
        send_word(32'h0000_0001);
        cmd_reset = 1'b1;
        @(negedge clk);
        cmd_reset = 1'b0;
        send_word(32'h0000_0000);
        check("R9 new header", 32'(pkt_valid), 32'd1);
        check("R9 header", pkt_header, 32'h0000_0000);
        check("R9 len", 32'(pkt_len), 32'd1);
        ack_pkt();
        check("R9 env kept", env_regs[1*32 +: 32], 32'hE100_0ABC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed(8'h00, 1);
        t_fixed(8'h02, 3);
        t_fixed(8'h20, 4);
        t_fixed(8'h2C, 9);
        t_fixed(8'h3C, 12);
        t_fixed(8'h60, 3);
        t_fixed(8'h68, 2);
        t_fixed(8'h6C, 1);
        t_fixed(8'h80, 4);
        t_hold_read();
        t_poly_flat();
        t_poly_gour();
        t_saturate();
        t_image_write();
        t_image_read();
        t_env();
        t_cmd_reset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule